// File: doc/BRIEF.md
# Programmable-Modulus Delta-Sigma Divide-Ratio Generator

This block feeds the feedback divider of a fractional-N synthesizer with a fresh integer divide value once per comparison cycle. It holds a chain of four first-order accumulators that wrap at a programmable modulus rather than at a power of two. Their overflow bits are recombined through successive differencing so that the quantisation noise of the selected order is pushed to high offsets. The instantaneous ratio is the programmed integer part plus that signed correction. Its long-run mean is the integer part plus FRAC/MOD, or plus (2·FRAC+1)/(2·MOD) when dither is on.

The divider takes values over a valid/ready stream. A registered value is offered with `ratio_valid` high and stays stable until the divider raises `ratio_ready`. Each accepted beat advances the modulator by exactly one step, and the modulator never runs ahead of the consumer. Once filled, `ratio_valid` stays high. The only exceptions are reset and a change of any configuration input; in either case the held value is discarded and the sequence restarts from cleared accumulators. Integer parts of 512 and above switch the fractional machinery off.

Top module: `frac_ratio_gen`

## Requirements
- R1: While reset is low, and on the first rising edge after it, `ratio_valid` is 0 and `ratio` is 0. Accumulators and difference histories start from zero.
- R2: When `ratio_valid` is high and `ratio_ready` is low, `ratio` and `ratio_valid` hold at the next edge and the modulator does not step. Each handshake advances the modulator exactly one step. `ratio_valid` never falls except through reset or a configuration change.
- R3: `order_sel` selects the number of active stages: 2'b10 = one, 2'b01 = two, 2'b00 = three, 2'b11 = four. The output is int_part + c1 + (1−z⁻¹)c2 + (1−z⁻¹)²c3 + (1−z⁻¹)³c4, where ck is the carry of stage k and inactive stages contribute 0.
- R4: A stage adds its input to its accumulator. When the sum is at least the modulus, the stage subtracts the modulus and carries 1. Stage 1 takes FRAC, and stage k takes the new residue of stage k−1. With one stage and no dither, MOD beats from a cleared state sum to MOD·int_part + FRAC.
- R5: With `dither_en` = 1, every stage wraps at 2·MOD and stage 1 takes 2·FRAC+1. With one stage, 2·MOD beats from a cleared state sum to 2·MOD·int_part + 2·FRAC + 1.
- R6: When int_part is 512 or more, every offered value equals int_part, whatever FRAC, MOD, order and dither are set to. At int_part = 511 the fractional path is active.
- R7: A change in any of int_part, frac_num, frac_mod, order_sel or dither_en clears all accumulators and histories at the next edge and deasserts `ratio_valid` for that one cycle. The next value is the first step from zero state.
- R8: MOD up to 2097151 with FRAC up to MOD−1, with or without dither, produces the exact R3 sequence with no accumulator overflow.
- R9: The correction added to int_part lies in [0,1] for one stage, [−1,2] for two, [−3,4] for three and [−7,8] for four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_part | input | 17 | Integer part of the divide ratio |
| frac_num | input | 21 | Fractional numerator FRAC |
| frac_mod | input | 21 | Fractional modulus MOD (2 or more) |
| order_sel | input | 2 | Modulator order code (see R3) |
| dither_en | input | 1 | Adds half an LSB of fraction |
| ratio_valid | output | 1 | Divide value offered |
| ratio_ready | input | 1 | Divider takes the offered value this edge |
| ratio | output | 17 | Instantaneous integer divide value |

## Verification
A wrong accumulator residue or a stale difference history shows up as a ratio that departs from the reference sequence on the very next accepted beat. It also shifts the windowed sum of a first-order run by at least one. A modulator that steps while the divider stalls is seen at the port as a value that changes under a low ready, or as a skipped entry once ready returns. A missed configuration clear shows up one cycle after the change, as `ratio_valid` staying high, followed by a sequence that does not start from zero state. A wrong order decode breaks the per-order correction bounds within a few beats.

// File: rtl/frac_ratio_pkg.sv
package frac_ratio_pkg;

  localparam int DEF_INT_W     = 17;
  localparam int DEF_FRAC_W    = 21;
  localparam int DEF_STAGES    = 4;
  localparam int DEF_INT_LIMIT = 512;

  // Order code to number of active stages: 10->1, 01->2, 00->3, 11->4.
  function automatic logic [2:0] stages_for_code(input logic [1:0] code);
    logic [2:0] n;
    case (code)
      2'b10:   n = 3'd1;
      2'b01:   n = 3'd2;
      2'b00:   n = 3'd3;
      default: n = 3'd4;
    endcase
    return n;
  endfunction

  // Binomial coefficient, zero when k exceeds n.
  function automatic int binom(input int n, input int k);
    int r;
    if (k > n || k < 0) return 0;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * (n - i)) / (i + 1);
    return r;
  endfunction

endpackage

// File: rtl/frac_cfg_guard.sv
module frac_cfg_guard #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  output logic             changed
);
  logic [CFG_W-1:0] cfg_q;

  // The shadow copy follows the inputs even during reset, so leaving reset
  // with unchanged settings needs no extra clear cycle.
  always_ff @(posedge clk) begin
    cfg_q <= cfg;
  end

  assign changed = rst_n && (cfg != cfg_q);
endmodule

// File: rtl/frac_acc_stage.sv
module frac_acc_stage #(
  parameter int ACC_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [ACC_W-1:0] modulus,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] residual,
  output logic             carry
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, addend};
    carry    = (sum >= {1'b0, modulus});
    residual = ACC_W'(carry ? (sum - {1'b0, modulus}) : sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (adv)      acc_q <= residual;
  end
endmodule

// File: rtl/frac_noise_shape.sv
module frac_noise_shape
  import frac_ratio_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int CORR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     adv,
  input  logic [STAGES-1:0]        carry,
  input  logic [2:0]               order,
  output logic signed [CORR_W-1:0] corr
);
  localparam int HIST_W = STAGES - 1;

  logic [STAGES-1:0] used;
  logic [HIST_W-1:0] hist_q [STAGES];

  // Carries of stages beyond the selected order are forced to zero so
  // their histories stay empty as well.
  always_comb begin
    for (int k = 0; k < STAGES; k++) used[k] = carry[k] && (k < int'(order));
  end

  // Stage k (0-based) is differenced k times: sum_j (-1)^j C(k,j) c[n-j].
  always_comb begin
    corr = '0;
    for (int k = 0; k < STAGES; k++) begin
      corr = corr + CORR_W'(used[k]);
      for (int j = 1; j <= HIST_W; j++) begin
        if (hist_q[k][j-1]) begin
          if (j % 2 == 1) corr = corr - CORR_W'(binom(k, j));
          else            corr = corr + CORR_W'(binom(k, j));
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rst_n || clr) hist_q[g] <= '0;
        else if (adv)      hist_q[g] <= (hist_q[g] << 1) | HIST_W'(used[g]);
      end
    end
  endgenerate
endmodule

// File: rtl/frac_ratio_gen.sv
module frac_ratio_gen
  import frac_ratio_pkg::*;
#(
  parameter int INT_W     = DEF_INT_W,
  parameter int FRAC_W    = DEF_FRAC_W,
  parameter int STAGES    = DEF_STAGES,
  parameter int INT_LIMIT = DEF_INT_LIMIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_part,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_mod,
  input  logic [1:0]        order_sel,
  input  logic              dither_en,
  output logic              ratio_valid,
  input  logic              ratio_ready,
  output logic [INT_W-1:0]  ratio
);
  localparam int ACC_W  = FRAC_W + 1;
  localparam int CFG_W  = INT_W + 2 * FRAC_W + 3;
  localparam int CORR_W = STAGES + 1;

  logic [CFG_W-1:0]         cfg_vec;
  logic                     cfg_changed;
  logic                     bypass;
  logic                     advance;
  logic                     stage_clr;
  logic [ACC_W-1:0]         eff_mod;
  logic [ACC_W-1:0]         link [STAGES+1];
  logic [STAGES-1:0]        carry;
  logic [2:0]               order_num;
  logic signed [CORR_W-1:0] corr;
  logic [INT_W-1:0]         corr_ext;
  logic [INT_W-1:0]         ratio_next;
  logic                     unused_tail;
  logic                     valid_q;
  logic [INT_W-1:0]         ratio_q;

  assign cfg_vec = {int_part, frac_num, frac_mod, order_sel, dither_en};

  frac_cfg_guard #(.CFG_W(CFG_W)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg_vec),
    .changed (cfg_changed)
  );

  assign bypass    = (int_part >= INT_W'(INT_LIMIT));
  assign order_num = stages_for_code(order_sel);
  assign advance   = (!valid_q || ratio_ready) && !cfg_changed;
  assign stage_clr = cfg_changed || bypass;

  // Dither doubles the modulus and feeds 2*FRAC+1 into the first stage.
  assign eff_mod = dither_en ? {frac_mod, 1'b0} : {1'b0, frac_mod};
  assign link[0] = dither_en ? {frac_num, 1'b1} : {1'b0, frac_num};

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      frac_acc_stage #(.ACC_W(ACC_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stage_clr),
        .adv      (advance),
        .modulus  (eff_mod),
        .addend   (link[g]),
        .residual (link[g+1]),
        .carry    (carry[g])
      );
    end
  endgenerate

  assign unused_tail = ^link[STAGES];

  frac_noise_shape #(.STAGES(STAGES), .CORR_W(CORR_W)) u_shape (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stage_clr),
    .adv   (advance),
    .carry (carry),
    .order (order_num),
    .corr  (corr)
  );

  assign corr_ext   = {{(INT_W-CORR_W){corr[CORR_W-1]}}, corr};
  assign ratio_next = bypass ? int_part : (int_part + corr_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ratio_q <= '0;
    end else if (cfg_changed) begin
      valid_q <= 1'b0;
    end else if (advance) begin
      valid_q <= 1'b1;
      ratio_q <= ratio_next;
    end
  end

  assign ratio_valid = valid_q;
  assign ratio       = ratio_q;
endmodule

// File: rtl/frac_ratio_gen_chk.sv
module frac_ratio_gen_chk #(
  parameter int INT_W     = 17,
  parameter int FRAC_W    = 21,
  parameter int INT_LIMIT = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INT_W-1:0]  int_part,
  input logic [FRAC_W-1:0] frac_num,
  input logic [FRAC_W-1:0] frac_mod,
  input logic [1:0]        order_sel,
  input logic              dither_en,
  input logic              ratio_valid,
  input logic              ratio_ready,
  input logic [INT_W-1:0]  ratio
);
  logic [INT_W+2*FRAC_W+2:0] cfg_now;
  int lo_off, hi_off;

  assign cfg_now = {int_part, frac_num, frac_mod, order_sel, dither_en};

  always_comb begin
    case (order_sel)
      2'b10:   begin lo_off = 0;  hi_off = 1; end
      2'b01:   begin lo_off = -1; hi_off = 2; end
      2'b00:   begin lo_off = -3; hi_off = 4; end
      default: begin lo_off = -7; hi_off = 8; end
    endcase
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> !ratio_valid);

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && !ratio_ready && cfg_now == $past(cfg_now))
      |=> (ratio_valid && $stable(ratio)));

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && cfg_now == $past(cfg_now)) |=> ratio_valid);

  a_r7_change_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_now != $past(cfg_now)) |=> !ratio_valid);

  a_r6_bypass_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && cfg_now == $past(cfg_now) && int_part >= INT_W'(INT_LIMIT))
      |-> (ratio == int_part));

  a_r9_corr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && cfg_now == $past(cfg_now) && int_part < INT_W'(INT_LIMIT))
      |-> (int'(ratio) >= int'(int_part) + lo_off &&
           int'(ratio) <= int'(int_part) + hi_off));
endmodule

bind frac_ratio_gen frac_ratio_gen_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .INT_LIMIT(INT_LIMIT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_part    (int_part),
  .frac_num    (frac_num),
  .frac_mod    (frac_mod),
  .order_sel   (order_sel),
  .dither_en   (dither_en),
  .ratio_valid (ratio_valid),
  .ratio_ready (ratio_ready),
  .ratio       (ratio)
);

// File: tb/frac_ratio_gen_tb_top.sv
module frac_ratio_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [16:0] t_int;
  logic [20:0] t_frac, t_mod;
  logic [1:0]  t_ord;
  logic        t_dith;
  logic        ready;
  logic        valid;
  logic [16:0] ratio;

  frac_ratio_gen dut_i (
    .clk(clk), .rst_n(rst_n), .int_part(t_int), .frac_num(t_frac),
    .frac_mod(t_mod), .order_sel(t_ord), .dither_en(t_dith),
    .ratio_valid(valid), .ratio_ready(ready), .ratio(ratio)
  );

  typedef struct packed {
    int         n_int;
    int         frac;
    int         modv;
    logic [1:0] ord;
    logic       dith;
    int         beats;
    int         sum;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{100,     3,       7,       2'b10, 1'b0, 7,  703},
    '{100,     3,       7,       2'b10, 1'b1, 14, 1407},
    '{200,     5,       13,      2'b01, 1'b0, 40, -1},
    '{300,     11,      17,      2'b00, 1'b0, 50, -1},
    '{40,      1000,    1023,    2'b11, 1'b1, 60, -1},
    '{600,     5,       13,      2'b11, 1'b0, 10, 6000},
    '{503,     2096000, 2097151, 2'b11, 1'b0, 40, -1},
    '{24,      0,       2,       2'b10, 1'b0, 4,  96},
    '{250,     2097150, 2097151, 2'b01, 1'b1, 40, -1},
    '{131071,  4,       9,       2'b00, 1'b1, 5,  655355},
    '{511,     1,       2,       2'b10, 1'b0, 2,  1023}
  };

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model built from R3/R4/R5/R6.
  int ma [4];
  int h2a, h3a, h3b, h4a, h4b, h4c;

  task automatic model_clear();
    for (int i = 0; i < 4; i++) ma[i] = 0;
    h2a = 0; h3a = 0; h3b = 0; h4a = 0; h4b = 0; h4c = 0;
  endtask

  function automatic int n_stages(input logic [1:0] code);
    case (code)
      2'b10: return 1;
      2'b01: return 2;
      2'b00: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic model_next(output int y);
    int m, inp, s, ord;
    int c [4];
    if (t_int >= 512) begin
      model_clear();
      y = int'(t_int);
      return;
    end
    m   = t_dith ? 2 * int'(t_mod) : int'(t_mod);
    inp = t_dith ? 2 * int'(t_frac) + 1 : int'(t_frac);
    ord = n_stages(t_ord);
    for (int k = 0; k < 4; k++) begin
      s = ma[k] + inp;
      if (s >= m) begin ma[k] = s - m; c[k] = 1; end
      else        begin ma[k] = s;     c[k] = 0; end
      inp = ma[k];
      if (k >= ord) c[k] = 0;
    end
    y = int'(t_int) + c[0] + (c[1] - h2a) + (c[2] - 2 * h3a + h3b)
        + (c[3] - 3 * h4a + 3 * h4b - h4c);
    h4c = h4b; h4b = h4a; h4a = c[3];
    h3b = h3a; h3a = c[2];
    h2a = c[1];
  endtask

  int run_sum;

  // One accepted beat at the current (negative) edge, ready already high.
  task automatic beat_now(input string tag);
    int e, lo, hi;
    model_next(e);
    check(int'(ratio) == e, tag, int'(ratio), e);
    if (t_int < 512) begin
      case (n_stages(t_ord))
        1: begin lo = 0;  hi = 1; end
        2: begin lo = -1; hi = 2; end
        3: begin lo = -3; hi = 4; end
        default: begin lo = -7; hi = 8; end
      endcase
      check(int'(ratio) - int'(t_int) >= lo && int'(ratio) - int'(t_int) <= hi,
            "R9", int'(ratio) - int'(t_int), hi);
    end
    run_sum += int'(ratio);
  endtask

  task automatic take_beats(input int n, input string tag);
    int cnt = 0;
    while (cnt < n) begin
      @(negedge clk);
      if (valid) begin
        beat_now(tag);
        cnt++;
      end
    end
  endtask

  task automatic apply(input int vi, input int fr, input int md,
                       input logic [1:0] od, input logic dt);
    @(negedge clk);
    ready = 1'b0;
    @(negedge clk);
    t_int = 17'(vi); t_frac = 21'(fr); t_mod = 21'(md); t_ord = od; t_dith = dt;
    @(negedge clk);
    check(!valid, "R7", int'(valid), 0);
    model_clear();
    ready = 1'b1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual no completion expected completion");
      finish_run();
    end
  end

  initial begin
    string tg;
    int held;
    rst_n = 1'b0; ready = 1'b0;
    t_int = '0; t_frac = '0; t_mod = '0; t_ord = 2'b00; t_dith = 1'b0;
    repeat (3) @(negedge clk);
    check(!valid, "R1", int'(valid), 0);
    check(ratio == '0, "R1", int'(ratio), 0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].n_int, VEC[i].frac, VEC[i].modv, VEC[i].ord, VEC[i].dith);
      run_sum = 0;
      tg = (VEC[i].n_int >= 512) ? "R6" : ((VEC[i].modv > 1000000) ? "R8" : "R3");
      take_beats(VEC[i].beats, tg);
      if (VEC[i].sum >= 0) begin
        tg = (VEC[i].n_int >= 512) ? "R6" : (VEC[i].dith ? "R5" : "R4");
        check(run_sum == VEC[i].sum, tg, run_sum, VEC[i].sum);
      end
    end

    // R2: stall holds the value and does not advance the modulator
    apply(300, 11, 17, 2'b00, 1'b0);
    take_beats(5, "R3");
    @(negedge clk);
    ready = 1'b0;
    held = int'(ratio);
    check(valid, "R2", int'(valid), 1);
    repeat (4) begin
      @(negedge clk);
      check(valid && int'(ratio) == held, "R2", int'(ratio), held);
    end
    ready = 1'b1;
    beat_now("R2");
    take_beats(6, "R2");

    // R7: change while a value is held discards it and restarts from zero
    @(negedge clk);
    ready = 1'b0;
    @(negedge clk);
    t_frac = 21'd7;
    @(negedge clk);
    check(!valid, "R7", int'(valid), 0);
    model_clear();
    ready = 1'b1;
    take_beats(10, "R7");

    // R1: reset in mid-stream
    @(negedge clk);
    ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!valid, "R1", int'(valid), 0);
    check(ratio == '0, "R1", int'(ratio), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    ready = 1'b1;
    take_beats(8, "R1");

    finish_run();
  end
endmodule